// File: doc/BRIEF.md
# Masked Priority Resolver with Vector Output

This block gathers interrupt requests from up to 128 source slots and reports the most urgent one to a processor. Every slot is wired with a 7-bit global priority level and a 7-bit vector number. A raw request line and a software force bit are ORed into the slot's pending status. A per-slot enable bit decides whether that pending status may take part in arbitration. A comparison tree picks the enabled pending slot with the smallest level number. Its vector is then registered into a 32-bit vector word and drives an interrupt line.

Software reaches the enable, force, pending and vector state through a word-wide register port. The address is split into a 2-bit bank field (upper bits) and a word index (lower bits). Banks: 0 = pending (read-only), 1 = enable (1 = unmasked), 2 = force, 3 = vector word (read-only). Word index n covers sources 32n to 32n+31, with source 32n+b at bit b. Reads return data on the clock edge where `reg_rd_i` is sampled high. Writes take effect on the edge where `reg_wr_i` is sampled high.

Top module: `pvr_top`

## Requirements
- R1: After a synchronous reset, the vector word is 0, `irq_o` is low, every force bit is 0 and every enable bit is 0, so all sources start masked.
- R2: The pending bank shows, one clock after sampling, the OR of each slot's raw request and force bit, whatever the enable bits hold.
- R3: A pending slot whose enable bit (bank 1) is 0 never contributes to the vector word.
- R4: Among enabled pending slots, the one with the numerically lowest priority level is reported; slot levels are distinct.
- R5: The vector word carries the winning vector in bits 6:0 and zeros in bits 31:7; it is 0 when no enabled slot is pending.
- R6: `irq_o` is high exactly when the vector word is nonzero.
- R7: A force bit set to 1 (bank 2) raises that slot's request with the slot's own level and vector while its raw line is idle, and it stays set until software writes 0 to it.
- R8: The vector word reflects a change of requests, enable or force bits on the first clock edge after the changed state is present, and not before.
- R9: Writes to the pending bank (0) or the vector bank (3) change no state.
- R10: The enable and force banks read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_SRC | Raw request lines, one per slot, level sensitive |
| slot_prio_i | input | NUM_SRC*LVL_W | Priority level of slot k at bits [k*LVL_W +: LVL_W]; lower wins |
| slot_vec_i | input | NUM_SRC*VEC_W | Vector of slot k at bits [k*VEC_W +: VEC_W] |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | {bank[1:0], word index} |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| vec_word_o | output | 32 | Registered vector word of the winning request |
| irq_o | output | 1 | Interrupt line, high while a vector is reported |

## Verification
Several properties are checked on every cycle. `irq_o` must agree with the vector word. A cleared enable set must yield a zero vector one cycle later. Stable requests and enables must hold the vector word stable. Force bits must not move without a write to their bank, and reset must clear the outputs. Some behaviour is only visible in the bench's scenarios: that the lowest level wins across several request patterns, that forced requests carry the slot's own vector, the exact one-cycle latency after an enable write, readback of the enable and force banks, and that writes to the read-only banks are ignored. The bench checks these against a linear search model.

// File: rtl/pvr_pkg.sv
package pvr_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    BANK_PEND  = 2'd0,
    BANK_EN    = 2'd1,
    BANK_FORCE = 2'd2,
    BANK_VEC   = 2'd3
  } bank_e;
endpackage

// File: rtl/pvr_regfile.sv
module pvr_regfile
  import pvr_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter logic [NUM_SRC-1:0] EN_RST = '0,
  localparam int WORDS  = NUM_SRC / DATA_W,
  localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] pending_i,
  input  logic [DATA_W-1:0]  vec_word_i,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] force_o,
  output logic [DATA_W-1:0]  rdata_o
);
  bank_e            bank;
  logic [IDX_W-1:0] idx;
  logic [NUM_SRC-1:0] en_q, force_q;

  assign bank = bank_e'(addr_i[ADDR_W-1 -: 2]);
  assign idx  = addr_i[IDX_W-1:0];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic hit;
    assign hit = wr_i && (idx == IDX_W'(w));

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[w*DATA_W +: DATA_W]    <= EN_RST[w*DATA_W +: DATA_W];
        force_q[w*DATA_W +: DATA_W] <= '0;
      end else if (hit) begin
        if (bank == BANK_EN)    en_q[w*DATA_W +: DATA_W]    <= wdata_i;
        if (bank == BANK_FORCE) force_q[w*DATA_W +: DATA_W] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_i) begin
      unique case (bank)
        BANK_PEND:  rdata_o <= pending_i[idx*DATA_W +: DATA_W];
        BANK_EN:    rdata_o <= en_q[idx*DATA_W +: DATA_W];
        BANK_FORCE: rdata_o <= force_q[idx*DATA_W +: DATA_W];
        default:    rdata_o <= vec_word_i;
      endcase
    end
  end

  assign en_o    = en_q;
  assign force_o = force_q;
endmodule

// File: rtl/pvr_min_tree.sv
module pvr_min_tree #(
  parameter int N     = 128,
  parameter int LVL_W = 7,
  parameter int VEC_W = 7,
  localparam int DEPTH  = (N > 1) ? $clog2(N) : 1,
  localparam int LEAVES = 1 << DEPTH
) (
  input  logic [N-1:0]       valid_i,
  input  logic [N*LVL_W-1:0] lvl_i,
  input  logic [N*VEC_W-1:0] vec_i,
  output logic               found_o,
  output logic [VEC_W-1:0]   vec_o
);
  for (genvar l = 0; l <= DEPTH; l++) begin : g_lvl
    localparam int W = LEAVES >> l;
    logic [W-1:0]       v;
    logic [W*LVL_W-1:0] p;
    logic [W*VEC_W-1:0] c;

    if (l == 0) begin : g_leaf
      if (LEAVES > N) begin : g_pad
        assign v = {{(LEAVES-N){1'b0}}, valid_i};
        assign p = {{((LEAVES-N)*LVL_W){1'b0}}, lvl_i};
        assign c = {{((LEAVES-N)*VEC_W){1'b0}}, vec_i};
      end else begin : g_exact
        assign v = valid_i;
        assign p = lvl_i;
        assign c = vec_i;
      end
    end else begin : g_node
      for (genvar j = 0; j < W; j++) begin : g_cmp
        logic             lv, rv, take_l;
        logic [LVL_W-1:0] lp, rp;
        assign lv = g_lvl[l-1].v[2*j];
        assign rv = g_lvl[l-1].v[2*j+1];
        assign lp = g_lvl[l-1].p[(2*j)*LVL_W +: LVL_W];
        assign rp = g_lvl[l-1].p[(2*j+1)*LVL_W +: LVL_W];
        assign take_l = lv && (!rv || (lp <= rp));
        assign v[j] = lv || rv;
        assign p[j*LVL_W +: LVL_W] = take_l ? lp : rp;
        assign c[j*VEC_W +: VEC_W] = take_l ? g_lvl[l-1].c[(2*j)*VEC_W +: VEC_W]
                                            : g_lvl[l-1].c[(2*j+1)*VEC_W +: VEC_W];
      end
    end
  end

  assign found_o = g_lvl[DEPTH].v[0];
  assign vec_o   = found_o ? g_lvl[DEPTH].c[VEC_W-1:0] : '0;
endmodule

// File: rtl/pvr_top.sv
module pvr_top
  import pvr_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int LVL_W   = 7,
  parameter int VEC_W   = 7,
  parameter logic [NUM_SRC-1:0] EN_RST = '0,
  localparam int WORDS  = NUM_SRC / DATA_W,
  localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SRC-1:0]       req_i,
  input  logic [NUM_SRC*LVL_W-1:0] slot_prio_i,
  input  logic [NUM_SRC*VEC_W-1:0] slot_vec_i,
  input  logic                     reg_wr_i,
  input  logic                     reg_rd_i,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic [DATA_W-1:0]        reg_wdata_i,
  output logic [DATA_W-1:0]        reg_rdata_o,
  output logic [DATA_W-1:0]        vec_word_o,
  output logic                     irq_o
);
  logic [NUM_SRC-1:0] en_w, force_w, raw_w, pend_q;
  logic               found_w;
  logic [VEC_W-1:0]   win_vec_w, vec_q;
  logic               irq_q;
  logic [DATA_W-1:0]  vec_word_w;

  assign raw_w = req_i | force_w;

  pvr_regfile #(.NUM_SRC(NUM_SRC), .EN_RST(EN_RST)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (reg_wr_i),
    .rd_i       (reg_rd_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .pending_i  (pend_q),
    .vec_word_i (vec_word_w),
    .en_o       (en_w),
    .force_o    (force_w),
    .rdata_o    (reg_rdata_o)
  );

  pvr_min_tree #(.N(NUM_SRC), .LVL_W(LVL_W), .VEC_W(VEC_W)) u_tree (
    .valid_i (raw_w & en_w),
    .lvl_i   (slot_prio_i),
    .vec_i   (slot_vec_i),
    .found_o (found_w),
    .vec_o   (win_vec_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      vec_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= raw_w;
      vec_q  <= win_vec_w;
      irq_q  <= found_w && (win_vec_w != '0);
    end
  end

  assign vec_word_w = {{(DATA_W-VEC_W){1'b0}}, vec_q};
  assign vec_word_o = vec_word_w;
  assign irq_o      = irq_q;
endmodule

// File: rtl/pvr_checker.sv
module pvr_checker #(
  parameter int NUM_SRC = 128,
  parameter int ADDR_W  = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] req_i,
  input logic [NUM_SRC-1:0] en_i,
  input logic [NUM_SRC-1:0] force_i,
  input logic               wr_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [31:0]        vec_word_i,
  input logic               irq_i
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (vec_word_i == 32'd0) && !irq_i);

  p_masked_none_r3: assert property (@(posedge clk) disable iff (rst)
    (en_i == '0) |=> (vec_word_i == 32'd0));

  p_irq_match_r6: assert property (@(posedge clk) disable iff (rst)
    irq_i == (vec_word_i != 32'd0));

  p_force_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(wr_i && addr_i[ADDR_W-1 -: 2] == 2'd2) |=> $stable(force_i));

  p_vec_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(req_i | force_i) && $stable(en_i)) |=> $stable(vec_word_i));
endmodule

bind pvr_top pvr_checker #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_i      (req_i),
  .en_i       (en_w),
  .force_i    (force_w),
  .wr_i       (reg_wr_i),
  .addr_i     (reg_addr_i),
  .vec_word_i (vec_word_o),
  .irq_i      (irq_o)
);

// File: tb/pvr_top_bench.sv
module pvr_top_bench;
  localparam int N = 128;
  localparam int LW = 7;
  localparam int VW = 7;
  localparam int AW = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    req = '0;
  logic [N*LW-1:0] prio;
  logic [N*VW-1:0] vecs;
  logic            wr = 1'b0, rd = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata, vword;
  logic            irq;

  logic [N-1:0] m_en = '0, m_force = '0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pvr_top u_pvr_top (
    .clk(clk), .rst(rst), .req_i(req), .slot_prio_i(prio), .slot_vec_i(vecs),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .vec_word_o(vword), .irq_o(irq)
  );

  function automatic logic [LW-1:0] lvl_of(input int i);
    return LW'((i * 37 + 5) % 128);
  endfunction
  function automatic logic [VW-1:0] vec_of(input int i);
    return VW'((i * 3) % 127 + 1);
  endfunction

  function automatic logic [31:0] model(input logic [N-1:0] eff);
    int best = 999;
    logic [31:0] r = 0;
    for (int i = 0; i < N; i++)
      if (eff[i] && int'(lvl_of(i)) < best) begin
        best = int'(lvl_of(i));
        r = {25'd0, vec_of(i)};
      end
    return r;
  endfunction

  function automatic logic [AW-1:0] ad(input logic [1:0] bank, input int w);
    return {bank, 2'(w)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic reg_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    if (a[AW-1:2] == 2'd1) m_en[32*a[1:0] +: 32] = d;
    if (a[AW-1:2] == 2'd2) m_force[32*a[1:0] +: 32] = d;
  endtask

  task automatic reg_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    rd = 1'b0;
  endtask

  function automatic logic [31:0] expect_vec();
    return model((req | m_force) & m_en);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 vector word after reset", vword, 0);
    chk("R1 irq after reset", {31'd0, irq}, 0);
    reg_read(ad(2'd1, 0), d);
    chk("R1 enable word0 after reset", d, 0);
    reg_read(ad(2'd2, 3), d);
    chk("R1 force word3 after reset", d, 0);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    @(negedge clk);
    req = '0; req[5] = 1'b1; req[70] = 1'b1;
    step(2);
    reg_read(ad(2'd0, 0), d);
    chk("R2 pending word0", d, 32'h20);
    reg_read(ad(2'd0, 2), d);
    chk("R2 pending word2", d, 32'h40);
    chk("R3 masked pending gives no vector", vword, 0);
  endtask

  task automatic t_mask();
    for (int w = 0; w < 4; w++) reg_write(ad(2'd1, w), 32'hFFFF_FFFF);
    step(1);
    chk("R4 two pending, all enabled", vword, expect_vec());
    chk("R6 irq with vector", {31'd0, irq}, 1);
    reg_write(ad(2'd1, 0), 32'hFFFF_FFDF);
    step(1);
    chk("R3 source 5 masked", vword, {25'd0, vec_of(70)});
    reg_write(ad(2'd1, 2), 32'hFFFF_FFBF);
    step(1);
    chk("R5 none enabled gives zero word", vword, 0);
    chk("R6 irq low with zero vector", {31'd0, irq}, 0);
    reg_write(ad(2'd1, 0), 32'hFFFF_FFFF);
    reg_write(ad(2'd1, 2), 32'hFFFF_FFFF);
  endtask

  task automatic t_priority();
    logic [N-1:0] pats [4];
    pats[0] = {N{1'b1}};
    pats[1] = {32'h8000_0001, 32'h0, 32'h0100_0000, 32'h0000_0300};
    pats[2] = {N/2{2'b10}};
    pats[3] = {N/4{4'b0001}};
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      req = pats[k];
      step(1);
      chk($sformatf("R4 pattern %0d lowest level wins", k), vword, expect_vec());
      chk($sformatf("R5 pattern %0d upper bits zero", k), {7'd0, vword[31:7]}, 0);
    end
    @(negedge clk);
    req = '0;
    step(1);
  endtask

  task automatic t_force();
    logic [31:0] d;
    reg_write(ad(2'd2, 1), 32'h8);
    step(1);
    chk("R7 forced idle source 35 vector", vword, {25'd0, vec_of(35)});
    step(5);
    reg_read(ad(2'd2, 1), d);
    chk("R7 force bit persists", d, 32'h8);
    chk("R7 still reported after cycles", vword, {25'd0, vec_of(35)});
    reg_write(ad(2'd2, 1), 32'h0);
    step(1);
    chk("R7 cleared force drops request", vword, 0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    req = '0; req[100] = 1'b1;
    step(1);
    reg_write(ad(2'd1, 3), 32'h0);
    chk("R8 no change in cycle of enable write", vword, {25'd0, vec_of(100)});
    step(1);
    chk("R8 change one clock after enable write", vword, 0);
    reg_write(ad(2'd1, 3), 32'hFFFF_FFFF);
    step(1);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    reg_write(ad(2'd0, 3), 32'hFFFF_FFFF);
    reg_write(ad(2'd3, 0), 32'hFFFF_FFFF);
    step(1);
    reg_read(ad(2'd0, 3), d);
    chk("R9 pending bank unaffected by write", d, 32'h10);
    chk("R9 vector word unaffected by write", vword, {25'd0, vec_of(100)});
    reg_read(ad(2'd3, 0), d);
    chk("R9 vector bank read", d, {25'd0, vec_of(100)});
    @(negedge clk);
    req = '0;
    step(1);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    reg_write(ad(2'd1, 2), 32'hA5C3_0F96);
    reg_read(ad(2'd1, 2), d);
    chk("R10 enable readback", d, 32'hA5C3_0F96);
    reg_write(ad(2'd2, 0), 32'h0000_0400);
    reg_read(ad(2'd2, 0), d);
    chk("R10 force readback", d, 32'h0000_0400);
    chk("R7 forced source 10 reported", vword, expect_vec());
    reg_write(ad(2'd2, 0), 32'h0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      prio[i*LW +: LW] = lvl_of(i);
      vecs[i*VW +: VW] = vec_of(i);
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_pending();
    t_mask();
    t_priority();
    t_force();
    t_latency();
    t_readonly();
    t_readback();
    step(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule